// File: doc/BRIEF.md
# Timer-Driven Compare Output Channel

This block is one compare output channel paced by its own up-counting timer. The timer runs from zero to a programmable period value and then returns to zero. That return marks the period boundary, and the block raises a single-cycle interrupt pulse in the cycle that follows it. The single output pin is driven in one of two ways, chosen by a mode register.

In dual-match mode, the counter reaching the primary compare value switches the output on. The counter reaching the secondary value switches it off. Both events act on the following cycle. A secondary value exactly one above the primary value gives a high time of exactly one count. In pulse-width mode, the secondary register holds a duty value. That value is copied into an active copy only at the period boundary. The output is high while the count is below the active duty. A duty of zero therefore gives a low output for the whole period, a duty of one gives a one-count pulse, and a duty larger than the period gives a high output for the whole period.

Software programs the channel through a write strobe, a two-bit register select and a data word. A timer enable pauses or runs counting.

Top module: `tmr_compare_out`

## Requirements
- R1: With `tmr_en` high, the count steps by one each cycle and goes from the period value back to 0, so the period lasts period+1 cycles. With `tmr_en` low, the count is frozen and no boundary occurs.
- R2: `period_irq` is high for exactly one cycle: the cycle in which the count shows 0 after a boundary.
- R3: In dual-match mode (mode bit 0 = 0), the count equalling the primary value drives `cmp_out` high from the next cycle.
- R4: In dual-match mode, the count equalling the secondary value drives `cmp_out` low from the next cycle. If both values match at the same count, the output goes low. A secondary value of primary+1 yields exactly one high cycle per period, and the output never stays high indefinitely.
- R5: In pulse-width mode (mode bit 0 = 1), `cmp_out` is high exactly while the count is below the active duty. An active duty of 0 keeps the output low for the whole period.
- R6: A duty write takes effect only at the next period boundary. After a change from 0 to 1, the next period shows a high output at count 0 only.
- R7: An active duty greater than the period value holds `cmp_out` high for every count of the period.
- R8: A write happens on a clock edge with `wr_en` high. `wr_sel` selects the target: 0 is the mode (bit 0 of `wr_data`), 1 is the primary value, 2 is the secondary/duty value, and 3 is the period.
- R9: While in pulse-width mode, the dual-match output state is cleared. After a return to dual-match mode, the output stays low until the next primary match.
- R10: After reset, `cmp_out` and `period_irq` are low, the count is 0, dual-match mode is selected, and the primary, secondary and active duty values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 primary, 2 secondary/duty, 3 period |
| wr_data | input | W | Write data |
| cmp_out | output | 1 | Compare output pin |
| period_irq | output | 1 | One-cycle pulse after each period boundary |

## Verification
The output-level properties assume that no mode write lands on the edge they examine. The full-duty property also assumes that the period has not been lowered below the running count. The bench keeps within both assumptions: it changes the mode only at known counts, and it shortens the period only right after a boundary, when the count is 1. All other settings are swept over a period of 7 with the timer running. Expected high times per period, and exact per-count output patterns, are computed from the compare values alone.

// File: rtl/tco_pkg.sv
package tco_pkg;
  typedef enum logic [0:0] {
    MODE_DUAL = 1'b0,
    MODE_PWM  = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_PRI  = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_PER  = 2'd3
  } sel_e;
endpackage

// File: rtl/tco_timer.sv
module tco_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap_evt,
  output logic         irq
);
  function automatic logic [W-1:0] step_count(input logic [W-1:0] c,
                                              input logic [W-1:0] p);
    return (c == p) ? '0 : c + W'(1);
  endfunction

  assign wrap_evt = tmr_en && (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= wrap_evt;
      if (tmr_en) cnt <= step_count(cnt, period);
    end
  end
endmodule

// File: rtl/tco_regs.sv
module tco_regs
  import tco_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] RST_PERIOD = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         wrap_evt,
  output mode_e        mode,
  output logic [W-1:0] pri,
  output logic [W-1:0] sec,
  output logic [W-1:0] period,
  output logic [W-1:0] duty_act,
  output logic         duty_load
);
  assign duty_load = wrap_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_DUAL;
      pri      <= '0;
      sec      <= '0;
      period   <= RST_PERIOD;
      duty_act <= '0;
    end else begin
      if (wr_en) begin
        case (sel_e'(wr_sel))
          SEL_MODE: mode   <= mode_e'(wr_data[0]);
          SEL_PRI:  pri    <= wr_data;
          SEL_SEC:  sec    <= wr_data;
          SEL_PER:  period <= wr_data;
          default:  ;
        endcase
      end
      if (duty_load) duty_act <= sec;
    end
  end
endmodule

// File: rtl/tco_outgen.sv
module tco_outgen
  import tco_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  mode_e        mode,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] pri,
  input  logic [W-1:0] sec,
  input  logic [W-1:0] duty_act,
  output logic         set_evt,
  output logic         clr_evt,
  output logic         dual_state,
  output logic         cmp_out
);
  // Level-based duty compare: no edge event exists that could be skipped.
  function automatic logic duty_level(input logic [W-1:0] c,
                                      input logic [W-1:0] d);
    return c < d;
  endfunction

  assign set_evt = tmr_en && (cnt == pri);
  assign clr_evt = tmr_en && (cnt == sec);

  always_ff @(posedge clk) begin
    if (!rst_n)                 dual_state <= 1'b0;
    else if (mode == MODE_PWM)  dual_state <= 1'b0;
    else if (clr_evt)           dual_state <= 1'b0;
    else if (set_evt)           dual_state <= 1'b1;
  end

  assign cmp_out = (mode == MODE_PWM) ? duty_level(cnt, duty_act) : dual_state;
endmodule

// File: rtl/tmr_compare_out.sv
module tmr_compare_out
  import tco_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] RST_PERIOD = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         cmp_out,
  output logic         period_irq
);
  mode_e        mode;
  logic [W-1:0] pri, sec, period_q, duty_act, cnt;
  logic         wrap_evt, duty_load, set_evt, clr_evt, dual_state;

  tco_regs #(.W(W), .RST_PERIOD(RST_PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wrap_evt(wrap_evt), .mode(mode), .pri(pri),
    .sec(sec), .period(period_q), .duty_act(duty_act), .duty_load(duty_load)
  );

  tco_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .period(period_q),
    .cnt(cnt), .wrap_evt(wrap_evt), .irq(period_irq)
  );

  tco_outgen #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode(mode), .cnt(cnt),
    .pri(pri), .sec(sec), .duty_act(duty_act), .set_evt(set_evt),
    .clr_evt(clr_evt), .dual_state(dual_state), .cmp_out(cmp_out)
  );
endmodule

// File: rtl/tco_checker.sv
module tco_checker
  import tco_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tmr_en,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input mode_e        mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period,
  input logic [W-1:0] duty_act,
  input logic         wrap_evt,
  input logic         duty_load,
  input logic         irq,
  input logic         set_evt,
  input logic         clr_evt,
  input logic         dual_state,
  input logic         cmp_out
);
  logic mode_wr;
  assign mode_wr = wr_en && (wr_sel == 2'd0);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en && (cnt != period) |=> cnt == $past(cnt) + W'(1));
  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt == '0);
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(cnt));
  p_irq_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == '0);
  p_dual_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DUAL) && set_evt && !clr_evt && !mode_wr |=> cmp_out);
  p_dual_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DUAL) && clr_evt && !mode_wr |=> !cmp_out);
  p_pwm_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM) && (duty_act == '0) |-> !cmp_out);
  p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_load |=> $stable(duty_act));
  p_duty_load_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    duty_load |=> irq);
  p_pwm_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM) && (duty_act > period) && (cnt <= period) |-> cmp_out);
  p_dual_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM) |=> !dual_state);
endmodule

bind tmr_compare_out tco_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .mode(mode), .cnt(cnt), .period(period_q), .duty_act(duty_act),
  .wrap_evt(wrap_evt), .duty_load(duty_load), .irq(period_irq),
  .set_evt(set_evt), .clr_evt(clr_evt), .dual_state(dual_state),
  .cmp_out(cmp_out)
);

// File: tb/tmr_compare_out_test.sv
module tmr_compare_out_test;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int P = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_en = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic cmp_out, period_irq;
  int checks = 0;
  int errors = 0;

  tmr_compare_out #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cmp_out(cmp_out),
    .period_irq(period_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(data);
    tick();
    wr_en = 1'b0;
  endtask

  // Stop at the negedge where the count shows 0 (irq high).
  task automatic sync_period();
    int guard = 0;
    tick();
    while (!period_irq && guard < 64) begin tick(); guard++; end
    if (!period_irq) check("R2 boundary seen", 0, 1);
  endtask

  task automatic high_count(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin hi += int'(cmp_out); tick(); end
  endtask

  function automatic int dual_expect(input int pr, input int sc);
    if (pr == sc) return 0;
    if (sc > pr) return sc - pr;
    return P + 1 - (pr - sc);
  endfunction

  function automatic int pwm_expect(input int d);
    return (d > P + 1) ? P + 1 : d;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, gap;
    repeat (3) tick();
    check("R10 reset cmp_out", int'(cmp_out), 0);
    check("R10 reset irq", int'(period_irq), 0);
    rst_n = 1'b1;
    tick();
    check("R10 after release cmp_out", int'(cmp_out), 0);
    wr(3, P);
    tmr_en = 1'b1;
    // R1: period length
    sync_period();
    gap = 0;
    do begin tick(); gap++; end while (!period_irq && gap < 64);
    check("R1 period length", gap, P + 1);
    // R2: pulse width
    tick();
    check("R2 irq single cycle", int'(period_irq), 0);
    // R1: hold while disabled
    sync_period();
    tmr_en = 1'b0;
    hi = 0;
    for (int i = 0; i < 20; i++) begin tick(); hi += int'(period_irq); end
    check("R1 frozen no boundary", hi, 0);
    tmr_en = 1'b1;
    // R8: period register by select 3
    sync_period();
    wr(3, 3);
    sync_period();
    gap = 0;
    do begin tick(); gap++; end while (!period_irq && gap < 64);
    check("R8 period write", gap, 4);
    wr(3, P);
    // R3 explicit pattern
    wr(1, 2); wr(2, 5);
    repeat (16) tick();
    sync_period();
    for (int k = 0; k <= P; k++) begin
      check("R3 dual pattern", int'(cmp_out), int'(k >= 3 && k <= 5));
      tick();
    end
    // R4 gap of one
    wr(1, 2); wr(2, 3);
    repeat (16) tick();
    sync_period();
    for (int k = 0; k <= P; k++) begin
      check("R4 gap one pattern", int'(cmp_out), int'(k == 3));
      tick();
    end
    // R3/R4 sweep
    for (int pr = 0; pr <= P; pr++) begin
      for (int sc = 0; sc <= P; sc++) begin
        wr(1, pr); wr(2, sc);
        repeat (16) tick();
        high_count(P + 1, hi);
        check(pr == sc ? "R4 same count low" : "R3_R4 dual high time", hi,
              dual_expect(pr, sc));
      end
    end
    // R9: mode switch clears dual state
    wr(1, 1); wr(2, 6);
    repeat (16) tick();
    sync_period();
    repeat (3) tick();
    check("R9 dual high before switch", int'(cmp_out), 1);
    wr(0, 1);
    wr(0, 0);
    check("R9 low after return k5", int'(cmp_out), 0);
    tick(); check("R9 low k6", int'(cmp_out), 0);
    tick(); check("R9 low k7", int'(cmp_out), 0);
    tick(); check("R9 low k0", int'(cmp_out), 0);
    tick(); check("R9 low k1", int'(cmp_out), 0);
    tick(); check("R9 set again k2", int'(cmp_out), 1);
    // PWM mode
    wr(0, 1);
    for (int d = 0; d <= P + 2; d++) begin
      wr(2, d);
      repeat (16) tick();
      high_count(P + 1, hi);
      check(d > P ? "R7 full duty" : "R5 duty high time", hi, pwm_expect(d));
    end
    // R5 per-count pattern
    wr(2, 3);
    repeat (16) tick();
    sync_period();
    for (int k = 0; k <= P; k++) begin
      check("R5 pwm pattern", int'(cmp_out), int'(k < 3));
      tick();
    end
    // R6: 0 to 1 change mid-period
    wr(2, 0);
    repeat (16) tick();
    sync_period();
    repeat (3) tick();
    wr(2, 1);
    for (int k = 4; k <= P; k++) begin
      check("R6 old duty kept", int'(cmp_out), 0);
      tick();
    end
    check("R6 one-count pulse k0", int'(cmp_out), 1);
    tick();
    check("R6 pulse ends k1", int'(cmp_out), 0);
    // R6: 2 to 5 mid-period
    wr(2, 2);
    repeat (16) tick();
    sync_period();
    repeat (3) tick();
    wr(2, 5);
    for (int k = 4; k <= P; k++) begin
      check("R6 buffered duty", int'(cmp_out), 0);
      tick();
    end
    for (int k = 0; k <= P; k++) begin
      check("R6 new duty", int'(cmp_out), int'(k < 5));
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule